// File: doc/BRIEF.md
# Five-Function ALU with Barrel Shifter

This block is a purely combinational arithmetic and logic unit for an 8-bit datapath. It takes two operands and a 3-bit operation code. It returns one result word and two status flags. The supported operations are wrap-around addition, wrap-around subtraction, bitwise OR, bitwise NAND and a short logical shift in either direction. The flags tell whether the result is zero and whether its top bit is set.

For a shift, the second operand is a small control word rather than data. Its low two bits give a distance of zero to three places, and the bit above them chooses the direction. The shift is built from two layers of two-way selects: one layer moves by one place and the other by two. The three unused operation codes are defined to give a zero result, so a stray code can never leak operand data. The block holds no state. Its outputs follow its inputs within the same cycle of the surrounding logic.

Top module: `alu5_core`

## Requirements
- R1: Operation code 3'b000 outputs (opnd_a + opnd_b) modulo 256.
- R2: Operation code 3'b001 outputs (opnd_a - opnd_b) modulo 256, with the second operand taken from the first.
- R3: Operation code 3'b010 outputs the bitwise OR of the two operands.
- R4: Operation code 3'b011 outputs the bitwise NAND of the two operands.
- R5: Operation code 3'b100 shifts opnd_a logically by the distance in opnd_b[1:0]. The shift goes left when opnd_b[2] is 1 and right when it is 0, and vacated positions fill with zeros.
- R6: During a shift, opnd_b[7:3] has no effect on the result or the flags.
- R7: Operation codes 3'b101, 3'b110 and 3'b111 output a result of zero, which gives zero_flag 1 and neg_flag 0.
- R8: zero_flag is 1 exactly when all eight result bits are 0.
- R9: neg_flag equals bit 7 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand; the value shifted for a shift |
| opnd_b | input | 8 | Second operand; for a shift, bit 2 is the direction and bits 1:0 the distance |
| op_sel | input | 3 | Operation code |
| result | output | 8 | Operation result |
| zero_flag | output | 1 | 1 when the result is zero |
| neg_flag | output | 1 | Copy of the result's most significant bit |

## Verification
The block has no registers, so any internal fault shows at the ports as soon as the inputs settle, in the same evaluation. A decode fault that enables two units at once shows as OR-ed garbage in the result. So does a reserved code that selects a unit. A swapped shift layer, or a lost fill bit, shows as a wrong bit pattern or as extra set bits for a known distance and direction. The directed vectors place operands at the wrap points, at all-ones and at zero, so that these patterns differ from the correct ones.

// File: rtl/alu5_pkg.sv
package alu5_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_ADD   = 3'b000;
  localparam logic [OP_W-1:0] OPC_SUB   = 3'b001;
  localparam logic [OP_W-1:0] OPC_OR    = 3'b010;
  localparam logic [OP_W-1:0] OPC_NAND  = 3'b011;
  localparam logic [OP_W-1:0] OPC_SHIFT = 3'b100;

  // one enable per functional unit; at most one set at a time
  typedef struct packed {
    logic en_add;
    logic en_sub;
    logic en_or;
    logic en_nand;
    logic en_shift;
  } unit_sel_t;

endpackage

// File: rtl/alu5_decode.sv
module alu5_decode
  import alu5_pkg::*;
(
  input  logic [OP_W-1:0] op_sel_i,
  output unit_sel_t       sel_o,
  output logic            reserved_o
);

  always_comb begin
    sel_o      = '0;
    reserved_o = 1'b0;
    case (op_sel_i)
      OPC_ADD:   sel_o.en_add   = 1'b1;
      OPC_SUB:   sel_o.en_sub   = 1'b1;
      OPC_OR:    sel_o.en_or    = 1'b1;
      OPC_NAND:  sel_o.en_nand  = 1'b1;
      OPC_SHIFT: sel_o.en_shift = 1'b1;
      default:   reserved_o     = 1'b1;
    endcase
  end

  always_comb begin
    AST_UNIT_ONEHOT: assert ($onehot0(sel_o)) else $error("unit select not one-hot");  // R1
    if (reserved_o) begin
      AST_RESERVED_NO_UNIT: assert (sel_o == '0) else $error("reserved code enabled a unit");  // R7
    end
  end

endmodule

// File: rtl/alu5_shifter.sv
module alu5_shifter #(
  parameter int WIDTH = 8,
  parameter int AMT_W = 2
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             left_i,
  output logic [WIDTH-1:0] data_o
);

  localparam int NSTAGE = AMT_W;

  logic [WIDTH-1:0] stage_val [0:NSTAGE];

  assign stage_val[0] = data_i;

  // layer i moves by 2**i places when amount bit i is set
  for (genvar i = 0; i < NSTAGE; i++) begin : g_layer
    localparam int STEP = 1 << i;
    logic [WIDTH-1:0] moved;
    assign moved          = left_i ? (stage_val[i] << STEP) : (stage_val[i] >> STEP);
    assign stage_val[i+1] = amount_i[i] ? moved : stage_val[i];
  end

  assign data_o = stage_val[NSTAGE];

  always_comb begin
    AST_SHIFT_NO_NEW_ONES: assert ($countones(data_o) <= $countones(data_i))
      else $error("shift created set bits");  // R5
    if (amount_i == '0) begin
      AST_SHIFT_ZERO_PASS: assert (data_o == data_i)
        else $error("zero-distance shift altered data");  // R5
    end
  end

endmodule

// File: rtl/alu5_flags.sv
module alu5_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o,
  output logic             neg_o
);

  assign zero_o = ~|value_i;
  assign neg_o  = value_i[WIDTH-1];

  always_comb begin
    if (zero_o) begin
      AST_ZERO_NOT_NEG: assert (!neg_o) else $error("zero and negative both set");  // R8
    end
  end

endmodule

// File: rtl/alu5_core.sv
module alu5_core
  import alu5_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = 2
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             neg_flag
);

  localparam int DIR_BIT = AMT_W;

  function automatic logic [WIDTH-1:0] f_add(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return x + y;
  endfunction

  function automatic logic [WIDTH-1:0] f_sub(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return x + ~y + 1'b1;
  endfunction

  function automatic logic [WIDTH-1:0] f_nand(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return ~(x & y);
  endfunction

  unit_sel_t        sel;
  logic             reserved_op;
  logic [WIDTH-1:0] sum_val;
  logic [WIDTH-1:0] diff_val;
  logic [WIDTH-1:0] or_val;
  logic [WIDTH-1:0] nand_val;
  logic [WIDTH-1:0] shift_val;
  logic [WIDTH-1:0] res_val;

  alu5_decode u_decode (
    .op_sel_i   (op_sel),
    .sel_o      (sel),
    .reserved_o (reserved_op)
  );

  assign sum_val  = f_add(opnd_a, opnd_b);
  assign diff_val = f_sub(opnd_a, opnd_b);
  assign or_val   = opnd_a | opnd_b;
  assign nand_val = f_nand(opnd_a, opnd_b);

  alu5_shifter #(
    .WIDTH (WIDTH),
    .AMT_W (AMT_W)
  ) u_shifter (
    .data_i   (opnd_a),
    .amount_i (opnd_b[AMT_W-1:0]),
    .left_i   (opnd_b[DIR_BIT]),
    .data_o   (shift_val)
  );

  // AND-OR select: no unit enabled (reserved code) leaves zero
  assign res_val = ({WIDTH{sel.en_add}}   & sum_val)
                 | ({WIDTH{sel.en_sub}}   & diff_val)
                 | ({WIDTH{sel.en_or}}    & or_val)
                 | ({WIDTH{sel.en_nand}}  & nand_val)
                 | ({WIDTH{sel.en_shift}} & shift_val);

  assign result = res_val;

  alu5_flags #(
    .WIDTH (WIDTH)
  ) u_flags (
    .value_i (res_val),
    .zero_o  (zero_flag),
    .neg_o   (neg_flag)
  );

  always_comb begin
    if (reserved_op) begin
      AST_RESERVED_ZERO: assert (result == '0 && zero_flag && !neg_flag)
        else $error("reserved code gave nonzero output");  // R7
    end
    if (sel.en_or) begin
      AST_OR_COVERS_A: assert ((result & opnd_a) == opnd_a)
        else $error("OR lost operand bits");  // R3
    end
  end

endmodule

// File: tb/test_alu5_core.sv
module test_alu5_core;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic [2:0] op_sel;
  logic [7:0] result;
  logic       zero_flag;
  logic       neg_flag;

  int n_cmp;
  int n_bad;
  bit done;

  alu5_core i_alu5_core (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .zero_flag (zero_flag),
    .neg_flag  (neg_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // independent reference model
  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op);
    logic [8:0] wide;
    logic [7:0] v;
    case (op)
      3'd0: begin wide = {1'b0, a} + {1'b0, b}; return wide[7:0]; end
      3'd1: begin wide = {1'b0, a} + 9'd256 - {1'b0, b}; return wide[7:0]; end
      3'd2: return a | b;
      3'd3: return ~(a & b);
      3'd4: begin
        v = a;
        for (int k = 0; k < int'(b[1:0]); k++)
          v = b[2] ? {v[6:0], 1'b0} : {1'b0, v[7:1]};
        return v;
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h (a=%02h b=%02h op=%0d)",
               req, got, exp, opnd_a, opnd_b, op_sel);
    end
  endtask

  task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op, input string req);
    logic [7:0] e;
    @(negedge clk);
    opnd_a = a;
    opnd_b = b;
    op_sel = op;
    #(CLK_PERIOD/4);
    e = model(a, b, op);
    chk(req, result, e);
    chk("R8", {7'd0, zero_flag}, {7'd0, (e == 8'h00)});
    chk("R9", {7'd0, neg_flag}, {7'd0, e[7]});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R1", result, 8'h00);
    chk("R8", {7'd0, zero_flag}, 8'd1);
    chk("R9", {7'd0, neg_flag}, 8'd0);
  endtask

  task automatic t_add;
    run(8'd3,   8'd4,   3'd0, "R1");
    run(8'd200, 8'd100, 3'd0, "R1");
    run(8'hFF,  8'h01,  3'd0, "R1");
    run(8'h40,  8'h40,  3'd0, "R1");
  endtask

  task automatic t_sub;
    run(8'd9, 8'd9,   3'd1, "R2");
    run(8'd5, 8'd7,   3'd1, "R2");
    run(8'h00, 8'hFF, 3'd1, "R2");
    run(8'h90, 8'h10, 3'd1, "R2");
  endtask

  task automatic t_or;
    run(8'hA0, 8'h05, 3'd2, "R3");
    run(8'h00, 8'h00, 3'd2, "R3");
    run(8'h0F, 8'hF0, 3'd2, "R3");
  endtask

  task automatic t_nand;
    run(8'hFF, 8'hFF, 3'd3, "R4");
    run(8'hF0, 8'h3C, 3'd3, "R4");
    run(8'h00, 8'h55, 3'd3, "R4");
  endtask

  task automatic t_shift;
    for (int c = 0; c < 8; c++) begin
      run(8'hB6, 8'(c), 3'd4, "R5");
      run(8'h81, 8'(c), 3'd4, "R5");
    end
  endtask

  task automatic t_shift_high_ignored;
    logic [7:0] base_res;
    logic       base_z;
    logic       base_n;
    for (int c = 0; c < 8; c++) begin
      run(8'h5A, 8'(c), 3'd4, "R5");
      base_res = result;
      base_z   = zero_flag;
      base_n   = neg_flag;
      run(8'h5A, 8'(c) | 8'hF8, 3'd4, "R6");
      chk("R6", result, base_res);
      chk("R6", {6'd0, zero_flag, neg_flag}, {6'd0, base_z, base_n});
    end
  endtask

  task automatic t_reserved;
    for (int op = 5; op < 8; op++) begin
      run(8'hFF, 8'hFF, 3'(op), "R7");
      run(8'h80, 8'h7F, 3'(op), "R7");
    end
  endtask

  initial begin
    n_cmp  = 0;
    n_bad  = 0;
    done   = 1'b0;
    rst    = 1'b1;
    opnd_a = 8'h00;
    opnd_b = 8'h00;
    op_sel = 3'd0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add();
    t_sub();
    t_or();
    t_nand();
    t_shift();
    t_shift_high_ignored();
    t_reserved();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule